// File: doc/BRIEF.md
# Grouped Priority DMA Channel Arbiter

This block decides, once per cycle, which of the DMA channels is served in the next transfer slot. Every channel carries a two-bit priority group code. In group mode the highest group that has a pending channel wins. Inside that group the channels take turns in round-robin order, and each group keeps its own rotation pointer. In deadline mode the group codes are ignored. The pending channel with the smallest remaining deadline count is served instead, and a tie goes to the lowest channel number.

Each channel has a deadline counter. Software loads it and it counts down on its own. Two level-sensitive external request lines can make fixed channels pending, and each line has a matching done pulse. The decision is registered, so the grant appears one clock after the request. A stall input blocks a decision for a cycle. The block sits between the channel request logic and the transfer engine, which consumes one granted channel per slot.

Top module: `dma_grp_arbiter`

## Requirements
- R1: While reset is asserted and on the first cycle after it, gnt_valid, gnt_onehot, gnt_idx and ext_done are all zero.
- R2: When stall is low and at least one channel is pending, gnt_valid is high in the next cycle. When no channel is pending, gnt_valid is low in the next cycle.
- R3: With edf_mode low, the granted channel belongs to the highest pending group. The group of channel i is grp_cfg[2i+1:2i], and code 3 is the highest while code 0 is the lowest.
- R4: Within the winning group, the grant goes to the first pending channel above the last channel granted in that group, wrapping from the top channel to channel 0. Each group has its own pointer, which starts so that channel 0 comes first after reset and changes only when a channel of that group is granted.
- R5: gnt_onehot has exactly one bit set, at position gnt_idx, whenever gnt_valid is high, and it is all zero otherwise.
- R6: With edf_mode high, the granted channel is the pending channel with the smallest deadline count, regardless of group. On equal counts the lowest channel index wins.
- R7: A channel's deadline count takes dl_value in the cycle after its dl_load bit is high. Otherwise it decreases by one per cycle and stays at zero once it gets there, and stall does not affect it. After reset every count is at its maximum value.
- R8: ext_req[k] makes channel k pending for as long as it is held high, in the same way as req[k].
- R9: ext_done[k] is high in exactly those cycles in which the grant outputs show channel k with gnt_valid high.
- R10: When stall is high, gnt_valid is low in the next cycle and no round-robin pointer moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 32 | Per-channel request levels |
| ext_req | input | 2 | External request lines, line k maps to channel k |
| grp_cfg | input | 64 | Two-bit priority group per channel |
| edf_mode | input | 1 | 1 selects smallest deadline, 0 selects grouped round-robin |
| dl_load | input | 32 | Per-channel deadline load strobes |
| dl_value | input | 8 | Value written to the deadline counters being loaded |
| stall | input | 1 | Blocks the decision in this cycle |
| gnt_valid | output | 1 | A grant is being presented |
| gnt_onehot | output | 32 | One-hot granted channel |
| gnt_idx | output | 5 | Index of the granted channel |
| ext_done | output | 2 | Done pulse for the external-request channels |

## Verification
Two things can happen in the same cycle: a deadline count is reloaded while the free-running decrement would also change it, and a deadline decision is made from the count that was present before that edge. The bench loads one channel's deadline in the cycle just before a deadline-mode request. It also lets counts reach zero so that two channels end up equal, then judges which channel wins against a reference model that tracks every count cycle by cycle. A stall that arrives while group requests are waiting is also combined with the rotation pointers. The order of grants after the stall shows whether a pointer moved.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
    localparam int ARB_CHANNELS   = 32;
    localparam int ARB_GROUPS     = 4;
    localparam int ARB_DL_BITS    = 8;
    localparam int ARB_EXT_LINES  = 2;

    typedef enum logic {
        SEL_GROUPED  = 1'b0,
        SEL_DEADLINE = 1'b1
    } sel_mode_e;
endpackage

// File: rtl/dma_rr_picker.sv
module dma_rr_picker #(
    parameter int NUM = 32,
    localparam int IW = (NUM > 1) ? $clog2(NUM) : 1
) (
    input  logic [NUM-1:0] pend,
    input  logic [IW-1:0]  last,
    output logic           found,
    output logic [IW-1:0]  pick
);
    // Searches upward from the channel after the last one granted, wrapping around.
    always_comb begin
        int c;
        found = 1'b0;
        pick  = '0;
        for (int off = 1; off <= NUM; off++) begin
            c = (int'(last) + off) % NUM;
            if (!found && pend[c]) begin
                found = 1'b1;
                pick  = IW'(c);
            end
        end
    end
endmodule

// File: rtl/dma_edf_picker.sv
module dma_edf_picker #(
    parameter int NUM = 32,
    parameter int DW  = 8,
    localparam int IW = (NUM > 1) ? $clog2(NUM) : 1
) (
    input  logic [NUM-1:0]         pend,
    input  logic [NUM-1:0][DW-1:0] dl,
    output logic                   found,
    output logic [IW-1:0]          pick
);
    logic [DW-1:0] best;

    // A strict less-than keeps the lower index when counts are equal.
    always_comb begin
        found = 1'b0;
        pick  = '0;
        best  = '1;
        for (int i = 0; i < NUM; i++) begin
            if (pend[i] && (!found || dl[i] < best)) begin
                found = 1'b1;
                pick  = IW'(i);
                best  = dl[i];
            end
        end
    end
endmodule

// File: rtl/dma_deadline_bank.sv
module dma_deadline_bank #(
    parameter int NUM = 32,
    parameter int DW  = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM-1:0]         load,
    input  logic [DW-1:0]          value,
    output logic [NUM-1:0][DW-1:0] dl
);
    typedef struct packed {
        logic [NUM-1:0][DW-1:0] cnt;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM; i++) begin
            if (load[i]) begin
                st_d.cnt[i] = value;
            end else if (st_q.cnt[i] != '0) begin
                st_d.cnt[i] = st_q.cnt[i] - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign dl = st_q.cnt;

    for (genvar g = 0; g < NUM; g++) begin : g_chk
        a_r7_load_takes: assert property (@(posedge clk) disable iff (!rst_n)
            load[g] |=> dl[g] == $past(value));
        a_r7_count_down: assert property (@(posedge clk) disable iff (!rst_n)
            (!load[g] && dl[g] != '0) |=> dl[g] == $past(dl[g]) - 1'b1);
        a_r7_floor: assert property (@(posedge clk) disable iff (!rst_n)
            (!load[g] && dl[g] == '0) |=> dl[g] == '0);
    end
endmodule

// File: rtl/dma_grp_arbiter.sv
module dma_grp_arbiter
    import dma_arb_pkg::*;
#(
    parameter int N_CH  = ARB_CHANNELS,
    parameter int N_GRP = ARB_GROUPS,
    parameter int DL_W  = ARB_DL_BITS,
    parameter int N_EXT = ARB_EXT_LINES,
    localparam int IW   = (N_CH > 1) ? $clog2(N_CH) : 1,
    localparam int GW   = (N_GRP > 1) ? $clog2(N_GRP) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_CH-1:0]      req,
    input  logic [N_EXT-1:0]     ext_req,
    input  logic [N_CH*GW-1:0]   grp_cfg,
    input  logic                 edf_mode,
    input  logic [N_CH-1:0]      dl_load,
    input  logic [DL_W-1:0]      dl_value,
    input  logic                 stall,
    output logic                 gnt_valid,
    output logic [N_CH-1:0]      gnt_onehot,
    output logic [IW-1:0]        gnt_idx,
    output logic [N_EXT-1:0]     ext_done
);
    typedef struct packed {
        logic                       vld;
        logic [N_CH-1:0]            oh;
        logic [IW-1:0]              idx;
        logic [N_EXT-1:0]           done;
        logic [N_GRP-1:0][IW-1:0]   ptr;
    } arb_st_t;

    arb_st_t st_d, st_q;

    logic [N_CH-1:0]                pend;
    logic [N_GRP-1:0][N_CH-1:0]     grp_pend;
    logic [N_GRP-1:0]               rr_found;
    logic [N_GRP-1:0][IW-1:0]       rr_pick;
    logic [N_CH-1:0][DL_W-1:0]      dl_cnt;
    logic                           edf_found;
    logic [IW-1:0]                  edf_pick;
    logic [GW-1:0]                  win_grp;
    logic [IW-1:0]                  sel;
    sel_mode_e                      mode;

    assign mode = sel_mode_e'(edf_mode);

    // External lines raise the low-numbered channels.
    always_comb begin
        pend = req;
        for (int k = 0; k < N_EXT; k++) begin
            pend[k] = req[k] | ext_req[k];
        end
    end

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        always_comb begin
            for (int i = 0; i < N_CH; i++) begin
                grp_pend[g][i] = pend[i] && (grp_cfg[i*GW +: GW] == GW'(g));
            end
        end

        dma_rr_picker #(.NUM(N_CH)) u_rr (
            .pend  (grp_pend[g]),
            .last  (st_q.ptr[g]),
            .found (rr_found[g]),
            .pick  (rr_pick[g])
        );
    end

    dma_deadline_bank #(.NUM(N_CH), .DW(DL_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (dl_load),
        .value (dl_value),
        .dl    (dl_cnt)
    );

    dma_edf_picker #(.NUM(N_CH), .DW(DL_W)) u_edf (
        .pend  (pend),
        .dl    (dl_cnt),
        .found (edf_found),
        .pick  (edf_pick)
    );

    // Ascending scan: the last non-empty group seen is the highest one.
    always_comb begin
        win_grp = '0;
        for (int g = 0; g < N_GRP; g++) begin
            if (rr_found[g]) begin
                win_grp = GW'(g);
            end
        end
    end

    assign sel = (mode == SEL_DEADLINE) ? edf_pick : rr_pick[win_grp];

    always_comb begin
        st_d      = st_q;
        st_d.vld  = 1'b0;
        st_d.oh   = '0;
        st_d.idx  = '0;
        st_d.done = '0;
        if (!stall && (|pend)) begin
            st_d.vld     = 1'b1;
            st_d.oh[sel] = 1'b1;
            st_d.idx     = sel;
            for (int k = 0; k < N_EXT; k++) begin
                st_d.done[k] = (sel == IW'(k));
            end
            st_d.ptr[grp_cfg[int'(sel)*GW +: GW]] = sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.vld  <= 1'b0;
            st_q.oh   <= '0;
            st_q.idx  <= '0;
            st_q.done <= '0;
            for (int g = 0; g < N_GRP; g++) begin
                st_q.ptr[g] <= IW'(N_CH - 1);
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign gnt_valid  = st_q.vld;
    assign gnt_onehot = st_q.oh;
    assign gnt_idx    = st_q.idx;
    assign ext_done   = st_q.done;

    a_r5_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> $countones(gnt_onehot) == 1);
    a_r5_bit_at_idx: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> gnt_onehot[gnt_idx]);
    a_r5_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !gnt_valid |-> gnt_onehot == '0);
    a_r2_issue: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && (|pend)) |=> gnt_valid);
    a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !(|pend) |=> !gnt_valid);
    a_r2_from_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && (|pend)) |=> pend[gnt_idx] || $past(pend[sel]));
    a_r10_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !gnt_valid);
    a_r10_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> st_q.ptr == $past(st_q.ptr));
    a_r6_edf_found: assert property (@(posedge clk) disable iff (!rst_n)
        (|pend) |-> edf_found);

    for (genvar k = 0; k < N_EXT; k++) begin : g_done_chk
        a_r9_done_match: assert property (@(posedge clk) disable iff (!rst_n)
            ext_done[k] |-> (gnt_valid && gnt_idx == IW'(k)));
        a_r8_ext_served: assert property (@(posedge clk) disable iff (!rst_n)
            (ext_req[k] && !stall) |=> gnt_valid);
    end
endmodule

// File: tb/dma_grp_arbiter_bench.sv
module dma_grp_arbiter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] req = '0;
    logic [1:0]  ext_req = '0;
    logic [63:0] grp_cfg = 64'hE4E4_E4E4_E4E4_E4E4;
    logic        edf_mode = 1'b0;
    logic [31:0] dl_load = '0;
    logic [7:0]  dl_value = '0;
    logic        stall = 1'b0;
    logic        gnt_valid;
    logic [31:0] gnt_onehot;
    logic [4:0]  gnt_idx;
    logic [1:0]  ext_done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    typedef struct {
        bit    v;
        int    idx;
        string tag;
    } exp_t;

    exp_t sb[$];
    int   m_ptr[4];
    int   m_dl[32];

    always #10 clk = ~clk;

    dma_grp_arbiter u_dma_grp_arbiter (
        .clk(clk), .rst_n(rst_n), .req(req), .ext_req(ext_req),
        .grp_cfg(grp_cfg), .edf_mode(edf_mode), .dl_load(dl_load),
        .dl_value(dl_value), .stall(stall), .gnt_valid(gnt_valid),
        .gnt_onehot(gnt_onehot), .gnt_idx(gnt_idx), .ext_done(ext_done)
    );

    // Monitor: pops one expected item per driven cycle, after the edge.
    always @(posedge clk) begin
        exp_t        e;
        logic [31:0] oh_exp;
        logic [1:0]  dn_exp;
        #2;
        if (sb.size() > 0) begin
            e = sb.pop_front();
            oh_exp = e.v ? (32'b1 << e.idx) : 32'b0;
            dn_exp[0] = e.v && e.idx == 0;
            dn_exp[1] = e.v && e.idx == 1;
            checks++;
            if (gnt_valid !== e.v || gnt_onehot !== oh_exp || ext_done !== dn_exp ||
                (e.v && gnt_idx !== 5'(e.idx))) begin
                errors++;
                $display("FAIL %s: valid=%0b idx=%0d onehot=%h done=%b expected valid=%0b idx=%0d onehot=%h done=%b",
                         e.tag, gnt_valid, gnt_idx, gnt_onehot, ext_done,
                         e.v, e.idx, oh_exp, dn_exp);
            end
        end
    end

    function automatic int grp_of(int ch);
        return int'(grp_cfg[ch*2 +: 2]);
    endfunction

    // Driver: sets inputs at a falling edge, predicts the grant, advances the model.
    task automatic step(input logic [31:0] r, input logic [1:0] e, input bit st,
                        input bit edf, input logic [31:0] ld, input logic [7:0] val,
                        input string tag);
        logic [31:0] pend;
        exp_t        x;
        int          best;
        int          g;
        req = r; ext_req = e; stall = st; edf_mode = edf; dl_load = ld; dl_value = val;
        pend = r | {30'b0, e};
        x.v = 0; x.idx = 0; x.tag = tag;
        if (!st && pend != 0) begin
            x.v = 1;
            if (edf) begin
                best = -1;
                for (int i = 0; i < 32; i++) begin
                    if (pend[i] && (best < 0 || m_dl[i] < m_dl[best])) best = i;
                end
                x.idx = best;
            end else begin
                g = -1;
                for (int i = 0; i < 32; i++) begin
                    if (pend[i] && grp_of(i) > g) g = grp_of(i);
                end
                for (int off = 1; off <= 32; off++) begin
                    int c = (m_ptr[g] + off) % 32;
                    if (x.idx == 0 && best_unset(pend, c, g)) begin
                        x.idx = c;
                        off = 33;
                    end
                end
            end
            m_ptr[grp_of(x.idx)] = x.idx;
        end
        sb.push_back(x);
        for (int i = 0; i < 32; i++) begin
            if (ld[i]) m_dl[i] = int'(val);
            else if (m_dl[i] > 0) m_dl[i] = m_dl[i] - 1;
        end
        @(negedge clk);
    endtask

    function automatic bit best_unset(logic [31:0] pend, int c, int g);
        return pend[c] && grp_of(c) == g;
    endfunction

    task automatic idle(input string tag);
        step('0, '0, 0, 0, '0, '0, tag);
    endtask

    initial begin
        for (int g = 0; g < 4; g++) m_ptr[g] = 31;
        for (int i = 0; i < 32; i++) m_dl[i] = 255;
        repeat (3) @(negedge clk);
        checks++;
        if (gnt_valid !== 1'b0 || gnt_onehot !== '0 || gnt_idx !== '0 || ext_done !== '0) begin
            errors++;
            $display("FAIL R1: valid=%0b onehot=%h idx=%0d done=%b expected all zero",
                     gnt_valid, gnt_onehot, gnt_idx, ext_done);
        end
        rst_n = 1'b1;
        idle("R1 first cycle");
        idle("R2 nothing pending");

        // R3: channels 5, 6, 7 sit in groups 1, 2, 3.
        step(32'h0000_00E0, '0, 0, 0, '0, '0, "R3 highest group");
        step(32'h0000_0060, '0, 0, 0, '0, '0, "R3 next group");
        step(32'h0000_0020, '0, 0, 0, '0, '0, "R2 single request");

        // R4: group 3 rotation over 3, 7, 11 (7 was granted before).
        for (int n = 0; n < 5; n++)
            step(32'h0000_0888, '0, 0, 0, '0, '0, "R4 group3 rotation");
        // Group 0 has its own pointer.
        for (int n = 0; n < 3; n++)
            step(32'h0000_0111, '0, 0, 0, '0, '0, "R4 group0 pointer");
        step(32'h0000_0088, '0, 0, 0, '0, '0, "R4 group3 resumes");

        // R10: stall holds grants and pointers.
        step(32'h0000_0888, '0, 1, 0, '0, '0, "R10 stall blocks");
        step(32'h0000_0888, '0, 1, 0, '0, '0, "R10 stall again");
        step(32'h0000_0888, '0, 0, 0, '0, '0, "R10 pointer kept");

        // R4 wrap with all channels in group 0.
        grp_cfg = '0;
        step(32'h4000_0002, '0, 0, 0, '0, '0, "R4 wrap a");
        step(32'h4000_0002, '0, 0, 0, '0, '0, "R4 wrap b");
        step(32'h4000_0002, '0, 0, 0, '0, '0, "R4 wrap c");
        grp_cfg = 64'hE4E4_E4E4_E4E4_E4E4;

        // R8, R9: external lines.
        step('0, 2'b10, 0, 0, '0, '0, "R8 ext line1");
        step('0, 2'b01, 0, 0, '0, '0, "R9 ext line0 done");
        step('0, 2'b01, 1, 0, '0, '0, "R9 no done under stall");
        step(32'h0000_0004, 2'b01, 0, 0, '0, '0, "R8 ext vs group2");

        // R6: deadline mode ignores groups.
        step('0, '0, 0, 0, 32'h0000_0080, 8'd20, "R7 load ch7");
        step('0, '0, 0, 0, 32'h0000_0100, 8'd8, "R7 load ch8");
        step(32'h0000_0180, '0, 0, 1, '0, '0, "R6 smaller deadline");
        step('0, '0, 0, 0, 32'h4000_1000, 8'd50, "R7 load equal");
        step(32'h4000_1000, '0, 0, 1, '0, '0, "R6 tie lowest index");
        // Load in the cycle just before a deadline decision.
        step('0, '0, 0, 0, 32'h4000_0000, 8'd3, "R7 reload ch30");
        step(32'h4000_1000, '0, 0, 1, '0, '0, "R6 reloaded wins");

        // R7: saturation makes equal counts.
        step('0, '0, 0, 0, 32'h0000_0004, 8'd3, "R7 load ch2");
        step('0, '0, 0, 0, 32'h0000_0008, 8'd1, "R7 load ch3");
        step(32'h0000_000C, '0, 0, 1, '0, '0, "R7 ch3 lower count");
        idle("R7 wait");
        idle("R7 wait");
        idle("R7 wait");
        step(32'h0000_000C, '0, 0, 1, '0, '0, "R7 both at zero");
        idle("R2 drain");
        @(negedge clk);
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R2: %0d expected items left, expected 0", sb.size());
        end
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule